// File: doc/BRIEF.md
# TDM Time Slot Interchange Switch

This block is a non-blocking time and space switch for serial PCM streams. Sixteen serial input lines each carry 32 eight-bit channels per frame, which gives 512 input channels. Eight serial output lines carry 256 output channels. A common frame strobe aligns all lines. Each bit lasts a fixed number of device clocks, either two or four. Every received channel byte is stored in a speech memory that is split into two halves by frame. Each output channel reads the byte that its entry in a connection memory names.

A processor fills the connection memory through a byte-wide port. Each entry names an input line, an input slot and an enable flag. A slot whose entry is disabled releases its output line to high impedance and lowers a per-line drive-enable signal. This lets the outputs of several switches be tied together to build larger fabrics. A switched byte always leaves exactly one frame after it arrived.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held, every `pcm_oe` bit is 0, every `pcm_out` line is high impedance, and `cpu_rdata` is 0.
- R2: When `frame_sync` is high at a clock edge, the following clock begins bit 0 of slot 0. A frame spans 32 slots of 8 bits, and each bit lasts `CLKS_PER_BIT` clocks. Every later strobe realigns the count.
- R3: Each input line is sampled on the first clock of every bit period. The first bit of a slot is the most significant bit of that slot's byte.
- R4: An enabled output slot drives, most significant bit first, the byte taken from the input line and slot named in its connection entry. Each bit holds for `CLKS_PER_BIT` clocks and `pcm_oe` stays high across the slot.
- R5: A byte received in frame k appears on the output in frame k+1. This includes input slot 31 routed to output slot 0 of the next frame, and input slot 0 routed to output slot 31.
- R6: An output slot whose entry has its enable flag clear holds `pcm_oe` low for the entire slot, with `pcm_out` high impedance. `pcm_oe` changes only at slot boundaries.
- R7: One input channel may feed any number of output channels in the same frame.
- R8: Entry addressing works as follows. `cpu_addr` = {output line, output slot, byte select}. On byte select 0, data bits [4:0] set the input slot. On byte select 1, bit 7 sets the enable flag and bits [3:0] set the input line. A write happens when `cpu_cs` and `cpu_we` are both high at a clock edge.
- R9: A read (`cpu_cs` high, `cpu_we` low) returns the addressed byte on `cpu_rdata` one clock later, with unused bits reading 0. `cpu_rdata` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame strobe; marks the last clock before slot 0 |
| pcm_in | input | N_IN | Serial input lines |
| pcm_out | output | N_OUT | Serial output lines, high impedance when not driving |
| pcm_oe | output | N_OUT | Per-line drive enable for the current slot |
| cpu_cs | input | 1 | Processor port select |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | log2(N_OUT)+log2(SLOTS)+1 | Entry index and byte select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |

## Verification
At the last clock of a frame, the speech memory swaps halves. In that same clock, the byte for output slot 0 is fetched. At that moment input slot 31 was written only a bit period earlier. A connection from input line 15 slot 31 to output slot 0 provokes this collision, and a second connection from input slot 0 to output slot 31 covers the opposite edge. A scoreboard predicts each output byte from the previous frame's stimulus, so a fetch from the wrong half or a stale byte shows up as a data mismatch. Each run also starts its frame strobe at an arbitrary counter phase, so realignment coincides with a slot fetch.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int N_IN         = 16,
  parameter int N_OUT        = 8,
  parameter int SLOTS        = 32,
  parameter int CLKS_PER_BIT = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      frame_sync,
  input  logic [N_IN-1:0]                           pcm_in,
  output logic [N_OUT-1:0]                          pcm_out,
  output logic [N_OUT-1:0]                          pcm_oe,
  input  logic                                      cpu_cs,
  input  logic                                      cpu_we,
  input  logic [$clog2(N_OUT)+$clog2(SLOTS):0]      cpu_addr,
  input  logic [7:0]                                cpu_wdata,
  output logic [7:0]                                cpu_rdata
);
  localparam int LW    = $clog2(N_IN);
  localparam int OW    = $clog2(N_OUT);
  localparam int SW    = $clog2(SLOTS);
  localparam int CPW   = $clog2(CLKS_PER_BIT);
  localparam int SLW   = CPW + 3;
  localparam int CNTW  = SW + SLW;
  localparam int EW    = LW + SW + 1;
  localparam int FRAME = SLOTS * 8 * CLKS_PER_BIT;
  localparam int NCM   = N_OUT * SLOTS;
  localparam int NSP   = 2 * N_IN * SLOTS;

  logic [CNTW-1:0] cnt;
  logic            wbank;
  logic [CPW-1:0]  phase;
  logic [2:0]      bitpos;
  logic [SW-1:0]   slot, nslot;
  logic            frame_end, slot_end, sample, last_bit, fbank;

  assign phase     = cnt[CPW-1:0];
  assign bitpos    = cnt[SLW-1:CPW];
  assign slot      = cnt[CNTW-1:SLW];
  assign frame_end = frame_sync | (cnt == CNTW'(FRAME - 1));
  assign slot_end  = frame_sync | (&cnt[SLW-1:0]);
  assign nslot     = frame_sync ? '0 : slot + 1'b1;
  assign fbank     = (nslot == '0) ? wbank : ~wbank;
  assign sample    = (phase == '0);
  assign last_bit  = sample & (&bitpos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      wbank <= 1'b0;
    end else begin
      cnt <= frame_end ? '0 : cnt + 1'b1;
      if (frame_end) wbank <= ~wbank;
    end
  end

  logic [6:0] sr [N_IN];
  logic [7:0] spmem [NSP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < N_IN; l++) sr[l] <= '0;
    end else if (sample) begin
      for (int l = 0; l < N_IN; l++) sr[l] <= {sr[l][5:0], pcm_in[l]};
    end
  end

  always_ff @(posedge clk) begin
    if (last_bit)
      for (int l = 0; l < N_IN; l++) spmem[{wbank, LW'(l), slot}] <= {sr[l], pcm_in[l]};
  end

  logic [EW-1:0]    cm [NCM];
  logic [OW+SW-1:0] cidx;
  logic [EW-1:0]    cent;
  logic             unused_wbits;

  assign cidx         = cpu_addr[OW+SW:1];
  assign cent         = cm[cidx];
  assign unused_wbits = ^cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCM; i++) cm[i] <= '0;
      cpu_rdata <= '0;
    end else if (cpu_cs) begin
      if (cpu_we) begin
        if (!cpu_addr[0]) cm[cidx][SW-1:0]   <= cpu_wdata[SW-1:0];
        else              cm[cidx][EW-1:SW]  <= {cpu_wdata[7], cpu_wdata[LW-1:0]};
      end else begin
        cpu_rdata <= cpu_addr[0] ? {cent[EW-1], {(7-LW){1'b0}}, cent[EW-2:SW]}
                                 : {{(8-SW){1'b0}}, cent[SW-1:0]};
      end
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    logic [EW-1:0] ent;
    logic [7:0]    tx;
    logic          oe;

    assign ent = cm[{OW'(g), nslot}];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx <= '0;
        oe <= 1'b0;
      end else if (slot_end) begin
        oe <= ent[EW-1];
        tx <= spmem[{fbank, ent[EW-2:SW], ent[SW-1:0]}];
      end
    end

    assign pcm_oe[g]  = oe;
    assign pcm_out[g] = oe ? tx[~bitpos] : 1'bz;

    AST_OE_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[SLW-1:0] != '0) |-> $stable(pcm_oe[g])) else $error("oe moved mid-slot"); // R6
  end

  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (cnt == '0)) else $error("sync did not realign"); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNTW'(FRAME - 1)) |=> (cnt == '0)) else $error("frame length wrong"); // R2
  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (wbank != $past(wbank))) else $error("speech bank did not swap"); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_cs && !cpu_we) |=> $stable(cpu_rdata)) else $error("rdata moved without read"); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (pcm_oe == '0 && cpu_rdata == '0)) else $error("reset state wrong"); // R1
endmodule

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;
  localparam int N_IN = 16, N_OUT = 8, SLOTS = 32, CPB = 2;
  localparam int SLOTCLK = 8 * CPB;
  localparam int FRAME   = SLOTS * SLOTCLK;

  logic clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0;
  logic [N_IN-1:0] pcm_in = '0;
  wire  [N_OUT-1:0] pcm_out, pcm_oe;
  logic cpu_cs = 1'b0, cpu_we = 1'b0;
  logic [8:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  wire  [7:0] cpu_rdata;

  always #4 clk = ~clk;

  tsi_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS), .CLKS_PER_BIT(CPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .pcm_in(pcm_in),
    .pcm_out(pcm_out), .pcm_oe(pcm_oe), .cpu_cs(cpu_cs), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

  typedef struct { bit oe; logic [7:0] val; string tag; } item_t;
  item_t q[$];

  int checks = 0, errors = 0;
  int cm_line [N_OUT][SLOTS];
  int cm_slot [N_OUT][SLOTS];
  bit cm_en   [N_OUT][SLOTS];
  string ctag [N_OUT][SLOTS];
  bit mon_on = 0;
  int fidx = 0, cpos = 0;

  function automatic logic [7:0] dat(int seed, int f, int l, int s);
    return 8'(seed * 31 + f * 53 + l * 17 + s * 7 + l * s * 3) ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cpu_write(logic [8:0] a, logic [7:0] d);
    @(negedge clk); cpu_cs = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_cs = 0; cpu_we = 0;
  endtask

  task automatic cpu_read(logic [8:0] a, logic [7:0] exp, string tag);
    @(negedge clk); cpu_cs = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk); cpu_cs = 0;
    check(cpu_rdata == exp, tag, "cpu read", cpu_rdata, exp);
  endtask

  task automatic cm_set(int o, int s, int line, int sl, bit en, string tag);
    cpu_write({3'(o), 5'(s), 1'b0}, 8'(sl));
    cpu_write({3'(o), 5'(s), 1'b1}, {en, 3'b000, 4'(line)});
    cm_line[o][s] = line; cm_slot[o][s] = sl; cm_en[o][s] = en; ctag[o][s] = tag;
  endtask

  task automatic run(int n, int seed);
    @(negedge clk); frame_sync = 1;
    mon_on = 1;
    for (int f = 0; f < n; f++) begin
      for (int c = 0; c < FRAME; c++) begin
        @(negedge clk);
        frame_sync = (c == FRAME - 1);
        for (int l = 0; l < N_IN; l++)
          pcm_in[l] = dat(seed, f, l, c / SLOTCLK) >> (7 - (c % SLOTCLK) / CPB);
        fidx = f; cpos = c;
        if (c == FRAME - 1 && f < n - 1)
          for (int s = 0; s < SLOTS; s++)
            for (int o = 0; o < N_OUT; o++) begin
              item_t it;
              it.oe  = cm_en[o][s];
              it.val = dat(seed, f, cm_line[o][s], cm_slot[o][s]);
              it.tag = cm_en[o][s] ? ctag[o][s] : "R6";
              q.push_back(it);
            end
      end
    end
    @(negedge clk); frame_sync = 0; mon_on = 0;
    check(q.size() == 0, "R5", "scoreboard left over", q.size(), 0);
  endtask

  // monitor
  logic [7:0] acc [N_OUT];
  bit oe_all [N_OUT];
  bit oe_any [N_OUT];
  initial forever begin
    @(negedge clk); #1;
    if (mon_on && fidx >= 1 && (cpos % CPB) == 0) begin
      int b;
      b = (cpos % SLOTCLK) / CPB;
      for (int o = 0; o < N_OUT; o++) begin
        if (b == 0) begin oe_all[o] = 1; oe_any[o] = 0; end
        acc[o][7 - b] = pcm_out[o];
        oe_all[o] &= pcm_oe[o];
        oe_any[o] |= pcm_oe[o];
        if (b == 7) begin
          item_t it;
          if (q.size() == 0) begin
            check(0, "R5", "scoreboard empty", 0, 1);
          end else begin
            it = q.pop_front();
            if (it.oe)
              check(oe_all[o] && acc[o] == it.val, it.tag,
                    $sformatf("out%0d slot%0d oe=%0b data", o, cpos / SLOTCLK, oe_all[o]),
                    acc[o], it.val);
            else
              check(!oe_any[o], it.tag,
                    $sformatf("out%0d slot%0d drive", o, cpos / SLOTCLK), oe_any[o], 0);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(pcm_oe == '0, "R1", "oe in reset", pcm_oe, 0);
    check(cpu_rdata == '0, "R1", "rdata in reset", cpu_rdata, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(pcm_oe == '0, "R1", "oe after reset", pcm_oe, 0);

    // R8 R9: field layout and unused bits
    cpu_write({3'd5, 5'd9, 1'b0}, 8'hF5);
    cpu_write({3'd5, 5'd9, 1'b1}, 8'hFC);
    cpu_read({3'd5, 5'd9, 1'b0}, 8'h15, "R8 R9");
    cpu_read({3'd5, 5'd9, 1'b1}, 8'h8C, "R8 R9");
    repeat (3) @(negedge clk);
    check(cpu_rdata == 8'h8C, "R9", "rdata held", cpu_rdata, 8'h8C);
    cpu_read({3'd5, 5'd10, 1'b1}, 8'h00, "R8 R9");

    // configuration A: scattered map with holes
    for (int o = 0; o < N_OUT; o++)
      for (int s = 0; s < SLOTS; s++)
        cm_set(o, s, (o * 2 + s) % N_IN, (s * 7 + o) % SLOTS, (s % 5) != 3, "R2 R3 R4 R5");
    run(3, 1);

    // configuration B: frame-edge corners and broadcast
    for (int o = 0; o < N_OUT; o++)
      for (int s = 0; s < SLOTS; s++)
        if (s == 12)           cm_set(o, s, 9, 4, 1, "R7");
        else if (o == 0 && s == 0)  cm_set(o, s, 15, 31, 1, "R5");
        else if (o == 7 && s == 31) cm_set(o, s, 0, 0, 1, "R5");
        else if (o == 3 && s == 20) cm_set(o, s, 6, 20, 1, "R4");
        else                   cm_set(o, s, 0, 0, 0, "R6");
    run(3, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule